// File: doc/BRIEF.md
# Two-Word-Burst Double-Data-Rate SRAM Core

This block is a synthesizable synchronous SRAM whose port moves two words per command, one on each half of a command cycle. Everything runs on one beat clock at twice the command rate. An internal half-cycle flag starts after reset on the half that samples commands and then flips every beat. It is brought out as `cmd_edge` so the driving logic knows which edges accept a command. A command is either a read or a write of one two-word location. The address LSB picks which word of the pair travels first, and the other word always follows on the next beat.

Writes use a late-commit holding register. The two write words and their byte selects are collected over the two beats of the command cycle. They enter the array at the start of the next command cycle. A read issued in that next cycle to the same location merges the held bytes over the array contents, so it sees the new data. Reads go through a short beat pipeline whose insertion point is set by a latency-mode input. The normal mode is one and a half command cycles and the fallback mode is one command cycle. Outside the beats that carry read words, the data bus is zero and its valid flag is low.

Top module: `ddr2b_sram`

## Requirements
- R1: Commands are sampled only on edges that close a beat with `cmd_edge` high. `sel`, `wr` and `addr` presented in a beat with `cmd_edge` low start nothing.
- R2: A command edge with `sel` low is a no-operation: `wr`, `addr`, `din` and `bsel` are ignored, and the array keeps its contents.
- R3: The first word of a burst is at word address `addr`. The second is at `addr` with bit 0 inverted, so the burst wraps inside the aligned pair.
- R4: Write word 0 and its `bsel` are taken on the command edge. Write word 1 and its `bsel` are taken on the following edge.
- R5: `bsel[i]` high writes bits `[i*BYTE_W +: BYTE_W]` of the beat's word. With `bsel[i]` low, that byte keeps its old value.
- R6: With `lat_short` low, read word 0 is on `dout` with `dout_vld` high in the beat after the third edge following the command edge, and word 1 is there in the next beat.
- R7: With `lat_short` high, read word 0 is presented after the second edge following the command edge, and word 1 follows one beat later.
- R8: A read on the command edge right after a write to the same pair returns the written bytes, merged per byte over the earlier contents.
- R9: In the first beat after reset, `dout_vld` is low, `dout` is zero and `cmd_edge` is high.
- R10: In every beat that carries no read word, `dout_vld` is low and `dout` is zero. After a no-operation or write command, the output is disabled in the slot where read data would have appeared.
- R11: Reads on consecutive command edges produce an unbroken run of valid beats, and every run has an even length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, two beats per command cycle |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Port select; high on a command edge starts a command |
| wr | input | 1 | 1 = write, 0 = read, sampled with `sel` |
| addr | input | ADDR_W | Word address; bit 0 is the burst start word |
| bsel | input | NBYTE | Per-byte write selects, active high, one set per beat |
| din | input | WORD_W | Write data, word 0 on command edge, word 1 on next edge |
| lat_short | input | 1 | 0 = 1.5-cycle read latency, 1 = 1-cycle read latency |
| cmd_edge | output | 1 | High in beats whose closing edge samples commands |
| dout | output | WORD_W | Read data, zero when not valid |
| dout_vld | output | 1 | High in beats carrying a read word |

## Verification
The properties assume that `lat_short` changes only while no read is in flight. If it switched under a pending read, the pipeline slot chosen at issue would no longer match the mode seen when the data comes out. They also assume that commands are presented only with `cmd_edge` high, and that reset is held for at least one edge. The bench waits until the output pipe is empty before it changes the mode. It drives every command from a task that first aligns to a beat with `cmd_edge` high. It reads only locations it has fully written first, so no array word is ever undefined when it is compared.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2
    } cmd_e;

    // Read pipeline geometry, in beats
    localparam int PIPE_LEN   = 4;
    localparam int SLOT_LONG  = 2;  // word 0 leaves after edge t+3
    localparam int SLOT_SHORT = 1;  // word 0 leaves after edge t+2

    function automatic cmd_e decode_cmd(input logic sel, input logic wr);
        if (!sel)
            return CMD_NOP;
        return wr ? CMD_WR : CMD_RD;
    endfunction

    function automatic int first_slot(input logic short_mode);
        return short_mode ? SLOT_SHORT : SLOT_LONG;
    endfunction

endpackage

// File: rtl/ddr2b_ctrl.sv
module ddr2b_ctrl
    import ddr2b_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic wr,
    output logic cmd_edge,
    output cmd_e cmd
);

    logic half_q;  // 0: the closing edge of this beat samples commands

    always_ff @(posedge clk) begin
        if (rst)
            half_q <= 1'b0;
        else
            half_q <= ~half_q;
    end

    assign cmd_edge = ~half_q;

    always_comb begin
        cmd = CMD_NOP;
        if (cmd_edge)
            cmd = decode_cmd(sel, wr);
    end

endmodule

// File: rtl/ddr2b_wbuf.sv
module ddr2b_wbuf
    import ddr2b_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int WORD_W = 36,
    parameter int NBYTE  = 4,
    localparam int PAIR_W = ADDR_W - 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cmd_edge,
    input  cmd_e                        cmd,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [WORD_W-1:0]           din,
    input  logic [NBYTE-1:0]            bsel,
    output logic                        pend_vld,
    output logic [PAIR_W-1:0]           pend_pair,
    output logic [1:0][WORD_W-1:0]      pend_data,
    output logic [1:0][NBYTE-1:0]       pend_mask
);

    logic second_q;   // next edge carries write word 1
    logic start_q;    // slot of write word 0

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld  <= 1'b0;
            second_q  <= 1'b0;
            start_q   <= 1'b0;
            pend_pair <= '0;
            pend_data <= '0;
            pend_mask <= '0;
        end else if (cmd_edge) begin
            // the previous holding contents commit in the array on this edge
            if (cmd == CMD_WR) begin
                pend_vld             <= 1'b1;
                second_q             <= 1'b1;
                start_q              <= addr[0];
                pend_pair            <= addr[ADDR_W-1:1];
                pend_data[addr[0]]   <= din;
                pend_mask[addr[0]]   <= bsel;
                pend_mask[~addr[0]]  <= '0;
            end else begin
                pend_vld <= 1'b0;
                second_q <= 1'b0;
            end
        end else if (second_q) begin
            pend_data[~start_q] <= din;
            pend_mask[~start_q] <= bsel;
            second_q            <= 1'b0;
        end
    end

endmodule

// File: rtl/ddr2b_array.sv
module ddr2b_array #(
    parameter int PAIRS  = 64,
    parameter int WORD_W = 36,
    parameter int BYTE_W = 9,
    parameter int NBYTE  = 4,
    localparam int PAIR_W = $clog2(PAIRS)
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic [PAIR_W-1:0]      wr_pair,
    input  logic [1:0][WORD_W-1:0] wr_data,
    input  logic [1:0][NBYTE-1:0]  wr_mask,
    input  logic [PAIR_W-1:0]      rd_pair,
    output logic [1:0][WORD_W-1:0] rd_data
);

    logic [1:0][WORD_W-1:0] mem [PAIRS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int s = 0; s < 2; s++) begin
                for (int b = 0; b < NBYTE; b++) begin
                    if (wr_mask[s][b])
                        mem[wr_pair][s][b*BYTE_W +: BYTE_W] <= wr_data[s][b*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    assign rd_data = mem[rd_pair];

endmodule

// File: rtl/ddr2b_rdpipe.sv
module ddr2b_rdpipe
    import ddr2b_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              lat_short,
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] word1,
    output logic [WORD_W-1:0] dout,
    output logic              dout_vld
);

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
    } beat_t;

    beat_t pipe [PIPE_LEN];
    int    k0;

    assign k0 = first_slot(lat_short);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PIPE_LEN; i++)
                pipe[i] <= '0;
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            for (int i = 0; i < PIPE_LEN; i++) begin
                if (load && i == k0)
                    pipe[i] <= '{vld: 1'b1, data: word0};
                else if (load && i == k0 + 1)
                    pipe[i] <= '{vld: 1'b1, data: word1};
                else if (i == PIPE_LEN - 1)
                    pipe[i] <= '0;
                else
                    pipe[i] <= pipe[(i + 1) % PIPE_LEN];
            end
            dout_vld <= pipe[0].vld;
            dout     <= pipe[0].vld ? pipe[0].data : '0;
        end
    end

endmodule

// File: rtl/ddr2b_sram.sv
module ddr2b_sram
    import ddr2b_pkg::*;
#(
    parameter int PAIRS  = 64,
    parameter int WORD_W = 36,
    parameter int BYTE_W = 9,
    parameter int NBYTE  = WORD_W / BYTE_W,
    parameter int ADDR_W = $clog2(PAIRS) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBYTE-1:0]  bsel,
    input  logic [WORD_W-1:0] din,
    input  logic              lat_short,
    output logic              cmd_edge,
    output logic [WORD_W-1:0] dout,
    output logic              dout_vld
);

    localparam int PAIR_W = ADDR_W - 1;

    cmd_e                   cmd;
    logic                   pend_vld;
    logic [PAIR_W-1:0]      pend_pair;
    logic [1:0][WORD_W-1:0] pend_data;
    logic [1:0][NBYTE-1:0]  pend_mask;
    logic [1:0][WORD_W-1:0] arr_data;
    logic [1:0][WORD_W-1:0] merged;
    logic [PAIR_W-1:0]      rd_pair;
    logic                   hit;
    logic                   commit;

    ddr2b_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .wr       (wr),
        .cmd_edge (cmd_edge),
        .cmd      (cmd)
    );

    ddr2b_wbuf #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .NBYTE  (NBYTE)
    ) u_wbuf (
        .clk       (clk),
        .rst       (rst),
        .cmd_edge  (cmd_edge),
        .cmd       (cmd),
        .addr      (addr),
        .din       (din),
        .bsel      (bsel),
        .pend_vld  (pend_vld),
        .pend_pair (pend_pair),
        .pend_data (pend_data),
        .pend_mask (pend_mask)
    );

    assign commit  = cmd_edge && pend_vld;
    assign rd_pair = addr[ADDR_W-1:1];

    ddr2b_array #(
        .PAIRS  (PAIRS),
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W),
        .NBYTE  (NBYTE)
    ) u_array (
        .clk     (clk),
        .wr_en   (commit),
        .wr_pair (pend_pair),
        .wr_data (pend_data),
        .wr_mask (pend_mask),
        .rd_pair (rd_pair),
        .rd_data (arr_data)
    );

    // held write bytes override the array for a read of the same pair
    assign hit = pend_vld && (pend_pair == rd_pair);

    for (genvar s = 0; s < 2; s++) begin : g_slot
        for (genvar b = 0; b < NBYTE; b++) begin : g_byte
            assign merged[s][b*BYTE_W +: BYTE_W] =
                (hit && pend_mask[s][b]) ? pend_data[s][b*BYTE_W +: BYTE_W]
                                         : arr_data[s][b*BYTE_W +: BYTE_W];
        end
    end

    ddr2b_rdpipe #(
        .WORD_W (WORD_W)
    ) u_rdpipe (
        .clk       (clk),
        .rst       (rst),
        .load      (cmd == CMD_RD),
        .lat_short (lat_short),
        .word0     (merged[addr[0]]),
        .word1     (merged[~addr[0]]),
        .dout      (dout),
        .dout_vld  (dout_vld)
    );

endmodule

// File: rtl/ddr2b_sram_chk.sv
module ddr2b_sram_chk (
    input logic clk,
    input logic rst,
    input logic sel,
    input logic wr,
    input logic lat_short,
    input logic cmd_edge,
    input logic dout_vld
);

    logic fresh_q;
    logic odd_q;

    always_ff @(posedge clk) begin
        fresh_q <= rst;
        if (rst)
            odd_q <= 1'b0;
        else
            odd_q <= dout_vld ? ~odd_q : 1'b0;
    end

    assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
        fresh_q |-> (!dout_vld && cmd_edge));

    assert_half_toggle_a_R1: assert property (@(posedge clk) disable iff (rst)
        cmd_edge |=> !cmd_edge);

    assert_half_toggle_b_R1: assert property (@(posedge clk) disable iff (rst)
        !cmd_edge |=> cmd_edge);

    assert_long_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_edge && sel && !wr && !lat_short) |=> ##3 dout_vld);

    assert_short_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_edge && sel && !wr && lat_short) |=> ##2 dout_vld);

    assert_idle_long_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_edge && !(sel && !wr) && !lat_short) |=> ##3 !dout_vld);

    assert_idle_short_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_edge && !(sel && !wr) && lat_short) |=> ##2 !dout_vld);

    assert_run_start_phase_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(dout_vld) |-> (cmd_edge != lat_short));

    assert_even_runs_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(dout_vld) |-> !odd_q);

endmodule

bind ddr2b_sram ddr2b_sram_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .wr        (wr),
    .lat_short (lat_short),
    .cmd_edge  (cmd_edge),
    .dout_vld  (dout_vld)
);

// File: tb/tb_ddr2b_sram.sv
module tb_ddr2b_sram;

    localparam int W  = 36;
    localparam int BW = 9;
    localparam int NB = 4;
    localparam int PAIRS = 64;
    localparam int AW = 7;
    localparam int RING = 256;

    logic          clk = 1'b0;
    logic          rst;
    logic          sel, wr, lat_short;
    logic [AW-1:0] addr;
    logic [NB-1:0] bsel;
    logic [W-1:0]  din;
    logic          cmd_edge;
    logic [W-1:0]  dout;
    logic          dout_vld;

    int n_chk = 0;
    int n_bad = 0;
    int nb = 0;
    bit mon_on = 0;
    bit done = 0;

    logic [W-1:0] ref_mem [2*PAIRS];
    bit           ev [RING];
    logic [W-1:0] ed [RING];
    string        et [RING];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) nb <= nb + 1;

    ddr2b_sram dut (
        .clk(clk), .rst(rst), .sel(sel), .wr(wr), .addr(addr), .bsel(bsel),
        .din(din), .lat_short(lat_short), .cmd_edge(cmd_edge),
        .dout(dout), .dout_vld(dout_vld)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // every beat: expected word or idle bus (R10)
    always @(negedge clk) begin
        if (mon_on) begin
            int idx;
            idx = nb % RING;
            if (ev[idx])
                check(dout_vld === 1'b1 && dout === ed[idx], et[idx],
                      {27'd0, dout_vld, dout}, {27'd0, 1'b1, ed[idx]});
            else
                check(dout_vld === 1'b0 && dout === '0, "R10 idle bus",
                      {27'd0, dout_vld, dout}, 64'd0);
            ev[idx] = 1'b0;
        end
    end

    function automatic void ref_write(input logic [AW-1:0] a, input logic [W-1:0] d,
                                      input logic [NB-1:0] m);
        for (int b = 0; b < NB; b++)
            if (m[b]) ref_mem[a][b*BW +: BW] = d[b*BW +: BW];
    endfunction

    task automatic align();
        @(negedge clk);
        if (!cmd_edge) @(negedge clk);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [W-1:0] d0,
                            input logic [NB-1:0] m0, input logic [W-1:0] d1,
                            input logic [NB-1:0] m1);
        align();
        sel = 1; wr = 1; addr = a; din = d0; bsel = m0;
        ref_write(a, d0, m0);                    // R4 word 0 with command
        @(negedge clk);
        sel = 0; wr = 0; addr = '0; din = d1; bsel = m1;
        ref_write(a ^ AW'(1), d1, m1);           // R3 partner word, R4 next beat
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string tag, input bit noisy);
        int off;
        align();
        sel = 1; wr = 0; addr = a;
        off = lat_short ? 3 : 4;
        ev[(nb + off) % RING] = 1'b1;
        ed[(nb + off) % RING] = ref_mem[a];
        et[(nb + off) % RING] = tag;
        ev[(nb + off + 1) % RING] = 1'b1;
        ed[(nb + off + 1) % RING] = ref_mem[a ^ AW'(1)];
        et[(nb + off + 1) % RING] = tag;
        @(negedge clk);
        // R1: a read request in the second half must start nothing
        sel = noisy; wr = 0; addr = noisy ? AW'(20) : '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            align();
            sel = 0; wr = 0;
        end
    endtask

    task automatic t_reset();
        check(dout_vld === 1'b0 && dout === '0, "R9 outputs after reset",
              {27'd0, dout_vld, dout}, 64'd0);
        check(cmd_edge === 1'b1, "R9 first beat is command half", {63'd0, cmd_edge}, 64'd1);
    endtask

    task automatic t_basic();
        do_write(AW'(4), 36'h1_2345_6789, 4'hF, 36'hA_BCDE_F012, 4'hF);
        do_write(AW'(20), 36'h0_0F0F_0F0F, 4'hF, 36'hF_F0F0_F0F0, 4'hF);
        idle(2);
        do_read(AW'(4), "R6 R3 long latency even start", 0);
        idle(4);
    endtask

    task automatic t_odd_start();
        do_write(AW'(7), 36'h7_7777_0001, 4'hF, 36'h6_6666_0002, 4'hF);
        idle(2);
        do_read(AW'(7), "R3 burst from odd word", 0);
        do_read(AW'(6), "R3 burst from even word", 0);
        idle(4);
    endtask

    task automatic t_mask();
        do_write(AW'(10), 36'hF_FFFF_FFFF, 4'hF, 36'hF_FFFF_FFFF, 4'hF);
        idle(1);
        do_write(AW'(10), 36'h0_0000_0000, 4'b0101, 36'h1_2312_3123, 4'b1000);
        idle(2);
        do_read(AW'(10), "R5 byte selects", 0);
        idle(4);
    endtask

    task automatic t_forward();
        do_write(AW'(12), 36'hC_0C0C_0C0C, 4'hF, 36'hD_0D0D_0D0D, 4'hF);
        do_read(AW'(12), "R8 forward full write", 0);
        do_write(AW'(14), 36'h5_5555_5555, 4'hF, 36'hA_AAAA_AAAA, 4'hF);
        idle(1);
        do_write(AW'(14), 36'h0_1111_1111, 4'b0011, 36'h0_2222_2222, 4'b1100);
        do_read(AW'(15), "R8 forward merged bytes", 0);
        idle(4);
    endtask

    task automatic t_b2b();
        do_read(AW'(4), "R11 back-to-back first", 0);
        do_read(AW'(20), "R11 back-to-back second", 0);
        do_read(AW'(7), "R11 back-to-back third", 0);
        idle(4);
    endtask

    task automatic t_deselect();
        align();
        sel = 0; wr = 1; addr = AW'(4); din = 36'hB_ADBA_DBAD; bsel = 4'hF;
        @(negedge clk);
        din = 36'hB_ADBA_DBAD;
        wr = 0;
        idle(1);
        do_read(AW'(4), "R2 deselect leaves data", 0);
        idle(4);
    endtask

    task automatic t_second_half();
        do_read(AW'(6), "R1 second-half request ignored", 1);
        idle(4);
    endtask

    task automatic t_short();
        lat_short = 1;
        do_read(AW'(4), "R7 short latency", 0);
        do_read(AW'(7), "R7 short latency odd start", 0);
        do_write(AW'(30), 36'h3_0303_0303, 4'hF, 36'h3_1313_1313, 4'hF);
        do_read(AW'(31), "R7 R8 short latency forward", 0);
        idle(4);
        lat_short = 0;
        idle(1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected 0 cycles remaining", 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < RING; i++) ev[i] = 1'b0;
        rst = 1; sel = 0; wr = 0; addr = '0; bsel = '0; din = '0; lat_short = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        #1;
        t_reset();
        mon_on = 1;
        t_basic();
        t_odd_start();
        t_mask();
        t_forward();
        t_b2b();
        t_deselect();
        t_second_half();
        t_short();
        idle(2);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule